// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches up to 32 external interrupt pins and turns their activity into interrupt requests. Each line has its own sense-select field that chooses low-level, high-level, rising-edge, falling-edge or both-edge detection. Every pin passes through a two-stage synchroniser. Edges are found by comparing the current synchronised sample with the sample from the previous cycle. A detection sets a sticky per-line flag. Software clears that flag by writing a 1 to its bit.

A separate enable mask gates the flags. The mask has a set access and a clear access, so software never needs a read-modify-write. Each line drives its own registered interrupt output. A 32-bit register port gives access to everything: a masked request view, the enable mask, the raw detect flags, the live pin levels, four per-type views and the per-line configuration words.

Top module: `ext_irq_detector`

## Requirements
- R1: After reset, every detect flag, enable bit, configuration field and interrupt output is zero. Reads of offsets 0x04, 0x100 and 0x180 return 0.
- R2: Each pin passes through two synchroniser flops. A read of offset 0x104 returns the old level while the read is issued in the cycle of the pin change or in the cycle after it. A read issued in the second cycle after the change returns the new level.
- R3: Offset 0x104 returns the synchronised level of every pin, with bit n for line n.
- R4: Line n's configuration word is at offset 0x180 + 4*n. It stores and reads back only wdata[5:0], and the upper bits read as 0.
- R5: Sense code 0x01 detects a low level and code 0x02 detects a high level. In these level modes the flag is set again on every cycle the level holds, so a clear has no lasting effect while the level persists.
- R6: Sense code 0x08 detects a rising edge, code 0x04 a falling edge and code 0x0C either edge. Each edge sets the flag once, and the flag stays cleared after a write-1 clear.
- R7: Any sense code other than 0x01, 0x02, 0x04, 0x08 and 0x0C disables detection for that line, including code 0x00 and the values 0x03 and 0x3F.
- R8: The detect flags are at offset 0x100. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged. A detection in the same cycle as a clear wins.
- R9: Writing 1s to offset 0x08 enables those lines and writing 1s to offset 0x04 disables them. Zero bits in either write have no effect. Reading offset 0x04 returns the enable mask.
- R10: Offset 0x00 reads the detect flags ANDed with the enable mask.
- R11: irq_o[n] is a register holding the AND of flag n and enable bit n from the previous cycle.
- R12: Four views return the flags of lines whose sense mode is high level (offset 0x108), low level (0x10C), rising or both edges (0x110), and falling or both edges (0x114).
- R13: rdata is loaded one cycle after rd_en is sampled, and it holds between reads. Unmapped offsets, including the write-only offset 0x08, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_LINES | External interrupt pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | NUM_LINES | Per-line interrupt outputs |

## Verification
The assertions assume that register offsets are word aligned and that at most one register access happens per cycle, because only then is each enable or flag update caused by a single write. The flag-clearing property also assumes that a line's detection term is not active in the clearing cycle. This is why level-mode lines are excluded through the detection vector itself. The stimulus changes pins on the falling clock edge and holds each new level for at least four cycles, so every edge is seen as one distinct sample pair. It issues reads and writes one at a time, always to aligned offsets.

// File: rtl/ext_irq_detector.sv
module ext_irq_detector #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int DW = 32;
  localparam int CW = 6;

  localparam logic [ADDR_W-1:0] OFS_REQ  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFS_ENCL = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] OFS_ENST = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] OFS_DET  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] OFS_MON  = ADDR_W'('h104);
  localparam logic [ADDR_W-1:0] OFS_HI   = ADDR_W'('h108);
  localparam logic [ADDR_W-1:0] OFS_LO   = ADDR_W'('h10C);
  localparam logic [ADDR_W-1:0] OFS_RISE = ADDR_W'('h110);
  localparam logic [ADDR_W-1:0] OFS_FALL = ADDR_W'('h114);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'('h180);

  localparam logic [CW-1:0] SNS_LOW  = 6'h01;
  localparam logic [CW-1:0] SNS_HIGH = 6'h02;
  localparam logic [CW-1:0] SNS_FALL = 6'h04;
  localparam logic [CW-1:0] SNS_RISE = 6'h08;
  localparam logic [CW-1:0] SNS_BOTH = 6'h0C;

  logic [NUM_LINES-1:0] sync1, sync2, prev;
  logic [NUM_LINES-1:0] det, en, hit;
  logic [NUM_LINES-1:0] is_lo, is_hi, is_rise, is_fall;
  logic [NUM_LINES-1:0] wmask;
  logic [CW-1:0]        cfg [NUM_LINES];
  logic [DW-1:0]        rd_mux;

  wire wr_det  = wr_en && (addr == OFS_DET);
  wire wr_enst = wr_en && (addr == OFS_ENST);
  wire wr_encl = wr_en && (addr == OFS_ENCL);

  assign wmask = wdata[NUM_LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    wire cfg_wr = wr_en && (addr == OFS_CFG + ADDR_W'(4 * g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg[g] <= '0;
      else if (cfg_wr) cfg[g] <= wdata[CW-1:0];
    end

    assign is_lo[g]   = (cfg[g] == SNS_LOW);
    assign is_hi[g]   = (cfg[g] == SNS_HIGH);
    assign is_rise[g] = (cfg[g] == SNS_RISE) || (cfg[g] == SNS_BOTH);
    assign is_fall[g] = (cfg[g] == SNS_FALL) || (cfg[g] == SNS_BOTH);
  end

  assign hit = (is_lo   & ~sync2)
             | (is_hi   &  sync2)
             | (is_rise &  sync2 & ~prev)
             | (is_fall & ~sync2 &  prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det   <= '0;
      en    <= '0;
      irq_o <= '0;
    end else begin
      det   <= (det & ~(wr_det ? wmask : '0)) | hit;
      if (wr_enst)      en <= en | wmask;
      else if (wr_encl) en <= en & ~wmask;
      irq_o <= det & en;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_REQ:  rd_mux = DW'(det & en);
      OFS_ENCL: rd_mux = DW'(en);
      OFS_DET:  rd_mux = DW'(det);
      OFS_MON:  rd_mux = DW'(sync2);
      OFS_HI:   rd_mux = DW'(det & is_hi);
      OFS_LO:   rd_mux = DW'(det & is_lo);
      OFS_RISE: rd_mux = DW'(det & is_rise);
      OFS_FALL: rd_mux = DW'(det & is_fall);
      default: begin
        for (int i = 0; i < NUM_LINES; i++)
          if (addr == OFS_CFG + ADDR_W'(4 * i)) rd_mux = DW'(cfg[i]);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ext_irq_detector_chk.sv
module ext_irq_detector_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [NUM_LINES-1:0] det,
  input logic [NUM_LINES-1:0] en,
  input logic [NUM_LINES-1:0] hit,
  input logic [NUM_LINES-1:0] irq_o
);
  wire w_det  = wr_en && (addr == ADDR_W'('h100));
  wire w_enst = wr_en && (addr == ADDR_W'('h008));
  wire w_encl = wr_en && (addr == ADDR_W'('h004));
  wire [NUM_LINES-1:0] wm = wdata[NUM_LINES-1:0];

  a_r11_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(det & en));

  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    w_det |=> (det & $past(wm & ~hit)) == '0);

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !w_det |=> ($past(det) & ~det) == '0);

  a_r9_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    w_enst |=> (en & $past(wm)) == $past(wm));

  a_r9_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    w_encl |=> (en & $past(wm)) == '0);

  a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_enst || w_encl) |=> $stable(en));
endmodule

bind ext_irq_detector ext_irq_detector_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .det(det), .en(en), .hit(hit), .irq_o(irq_o)
);

// File: tb/ext_irq_detector_bench.sv
module ext_irq_detector_bench;
  localparam int N = 32;
  localparam int AW = 9;
  localparam time HALF = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_i = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  always #HALF clk = ~clk;

  ext_irq_detector #(.NUM_LINES(N), .ADDR_W(AW)) u_ext_irq_detector (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(logic [N-1:0] e, string t);
    n_cmp++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, irq_o, e);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_irq('0, "R1 irq after reset");
    rd(9'h004, 32'h0, "R1 enable after reset");
    rd(9'h100, 32'h0, "R1 detect after reset");
    rd(9'h180, 32'h0, "R1 cfg0 after reset");

    // configure lines: 0 high, 1 low, 2 rise, 3 fall, 4 both, 5 bogus, 6 none
    wr(9'h180, 32'h02);
    wr(9'h184, 32'h01);
    wr(9'h188, 32'h08);
    wr(9'h18C, 32'h04);
    wr(9'h190, 32'hFFFF_FF0C);
    wr(9'h194, 32'h03);
    idle(3);
    rd(9'h100, 32'h2, "R5 low level detected on line1");
    rd(9'h10C, 32'h2, "R12 low view");
    rd(9'h188, 32'h08, "R4 cfg2 readback");
    rd(9'h190, 32'h0C, "R4 cfg4 upper bits dropped");
    rd(9'h194, 32'h03, "R4 cfg5 readback");
    rd(9'h104, 32'h0, "R3 monitor all low");

    // R9 enables
    wr(9'h008, 32'h0000_00FF);
    rd(9'h004, 32'hFF, "R9 enable set");
    rd(9'h000, 32'h2, "R10 request view");
    idle(1);
    chk_irq(32'h2, "R11 irq line1");

    // R5 clear while low level persists
    wr(9'h100, 32'h2);
    rd(9'h100, 32'h2, "R5 level re-sets after clear");

    pin_i = 32'h02;
    idle(5);
    wr(9'h100, 32'h2);
    rd(9'h100, 32'h0, "R8 clear takes once level gone");

    // R6 / R5 / R7 rising pins
    pin_i = 32'h77;
    idle(5);
    rd(9'h100, 32'h15, "R6 rise and R5 high detect, R7 bogus ignored");
    rd(9'h104, 32'h77, "R3 monitor levels");
    rd(9'h108, 32'h01, "R12 high view");
    rd(9'h110, 32'h14, "R12 rise view");
    rd(9'h114, 32'h10, "R12 fall view");
    rd(9'h000, 32'h15, "R10 request view");
    chk_irq(32'h15, "R11 irq lines 0 2 4");

    wr(9'h100, 32'h15);
    rd(9'h100, 32'h01, "R6 edges stay cleared, R5 high persists");

    pin_i = 32'h7F;
    idle(5);
    rd(9'h100, 32'h01, "R6 rising pin3 ignored in fall mode");
    pin_i = 32'h67;
    idle(5);
    rd(9'h100, 32'h19, "R6 falling edges line3 and line4");
    rd(9'h114, 32'h18, "R12 fall view");

    wr(9'h100, 32'h0);
    rd(9'h100, 32'h19, "R8 writing zero leaves flags");

    // R9 disable
    wr(9'h004, 32'h08);
    rd(9'h004, 32'hF7, "R9 enable clear");
    rd(9'h000, 32'h11, "R10 request masked");
    idle(1);
    chk_irq(32'h11, "R11 irq after disable");
    wr(9'h008, 32'h0);
    rd(9'h004, 32'hF7, "R9 zero write to set no effect");

    // R7 cfg7 all-ones is invalid; R2 latency on pin7
    wr(9'h19C, 32'hFF);
    rd(9'h19C, 32'h3F, "R4 cfg7 six bits");
    pin_i = 32'hE7;
    rd(9'h104, 32'h67, "R2 monitor old in change cycle");
    rd(9'h104, 32'h67, "R2 monitor old one cycle later");
    rd(9'h104, 32'hE7, "R2 monitor new after two cycles");
    idle(4);
    rd(9'h100, 32'h19, "R7 invalid code no detection");

    // R13 read behaviour
    rd(9'h008, 32'h0, "R13 write-only offset reads zero");
    rd(9'h17C, 32'h0, "R13 unmapped reads zero");
    idle(3);
    n_cmp++;
    if (rdata !== 32'h0) begin
      n_bad++;
      $display("FAIL R13 rdata hold: actual %h expected %h", rdata, 32'h0);
    end

    idle(2);
    summary();
  end
endmodule